// File: doc/BRIEF.md
# Register Rename Mapping Tracker

This block records, for every architectural register, which in-flight producer wrote it last. It also accounts for a pool of temporary rename registers. Each cycle a dispatch stage may present one allocation, which carries a destination register number and a producer tag. In the same cycle a completion stage may present one release, which carries a producer tag. Any stage may look up an architectural register and receive its latest producer tag with a valid bit.

Before it dispatches an instruction, the dispatch stage asks whether enough temporaries are free for the number of register writes that instruction needs. A pool limit of zero models an unbounded pool. The block keeps three usage counters: the number of mappings in use now, the peak of that number, and a lifetime count of mappings created. The lifetime count saturates at its maximum.

A write is taken to replace the whole register, including any overlapping wider or narrower views of it. Each table entry therefore holds exactly one producer.

Top module: `rename_map_tracker`

## Requirements
- R1: After reset every table entry reads invalid, and the in-use, peak and lifetime counters read zero.
- R2: An accepted allocation for register r with tag t makes a query of r return valid=1 and tag=t from the next cycle. This replaces whatever r held before.
- R3: A release with tag t clears every entry that currently holds tag t. Entries holding any other tag are unchanged.
- R4: When an accepted allocation and a release hit the same register in one cycle, the register holds the new allocation afterwards.
- R5: With a nonzero limit L, an allocation is accepted only while (in-use minus this cycle's effective release) is below L. A rejected allocation changes neither the table nor any counter.
- R6: In-use rises by one for each accepted allocation and falls by one for each release, but only when it is above zero. A release at zero leaves it at zero.
- R7: A release is applied before the allocation in the same cycle. With the pool full, allocation plus release is accepted and in-use stays at L.
- R8: The avail output is 1 exactly when the limit is zero or need_count <= L - in_use, using the registered in-use value.
- R9: peak_use equals the largest in-use value seen since reset.
- R10: total_created counts accepted allocations and holds at 2^LIFE_W-1 instead of wrapping.
- R11: With a limit of zero, avail is always 1 and every allocation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_reg | input | REG_W | Destination architectural register |
| alloc_tag | input | TAG_W | Producer tag of the allocation |
| rel_valid | input | 1 | Release request this cycle |
| rel_tag | input | TAG_W | Producer tag being released |
| query_reg | input | REG_W | Register to look up |
| query_valid | output | 1 | Looked-up register has an in-flight producer |
| query_tag | output | TAG_W | Producer tag of the looked-up register |
| need_count | input | NEED_W | Number of register writes to test for |
| avail | output | 1 | Enough temporaries are free for need_count |
| in_use | output | CNT_W | Mappings currently held |
| peak_use | output | CNT_W | Peak of in_use since reset |
| total_created | output | LIFE_W | Saturating count of accepted allocations |

## Verification
An allocation and a release can fall in the same cycle. They can collide on both the pool count and on one table entry. The bench provokes this in two ways. Directed steps fill the pool and then issue allocation plus release together, once on different registers and once where the released tag sits in the register being allocated. A long pseudo-random sweep also issues both often, with release tags drawn mostly from tags still live in the table. After every cycle an arithmetic model of the table and counters, which applies release first, is compared against every query result, every need value and all counters.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

  // True when a new mapping may be taken given the post-release in-use count.
  function automatic logic rmt_can_take(input int limit, input int in_after_rel);
    return (limit == 0) || (in_after_rel < limit);
  endfunction

  // True when need temporaries are free.
  function automatic logic rmt_has_room(input int limit, input int used, input int need);
    return (limit == 0) || (need <= (limit - used));
  endfunction

  // Saturating increment against an explicit ceiling.
  function automatic int rmt_sat_inc(input int value, input logic inc, input int ceiling);
    return (inc && (value < ceiling)) ? value + 1 : value;
  endfunction

  // Larger of two values.
  function automatic int rmt_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rmt_map_table.sv
module rmt_map_table #(
  parameter int NUM_REGS = 16,
  parameter int TAG_W    = 5,
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_reg,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic [REG_W-1:0] rd_reg,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag
);

  logic [NUM_REGS-1:0] ent_valid;
  logic [TAG_W-1:0]    ent_tag [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    logic hit_wr;
    logic hit_clr;
    assign hit_wr  = wr_en && (wr_reg == REG_W'(g));
    assign hit_clr = clr_en && ent_valid[g] && (ent_tag[g] == clr_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_tag[g]   <= '0;
      end else if (hit_wr) begin
        ent_valid[g] <= 1'b1;
        ent_tag[g]   <= wr_tag;
      end else if (hit_clr) begin
        ent_valid[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_valid = 1'b0;
    rd_tag   = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_reg == REG_W'(i)) begin
        rd_valid = ent_valid[i];
        rd_tag   = ent_valid[i] ? ent_tag[i] : '0;
      end
    end
  end

endmodule

// File: rtl/rmt_pool_ctr.sv
module rmt_pool_ctr
  import rmt_pkg::*;
#(
  parameter int POOL_LIMIT = 8,
  parameter int CNT_W      = 8,
  parameter int NEED_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic              rel_req,
  input  logic [NEED_W-1:0] need,
  output logic              alloc_ok,
  output logic              rel_ok,
  output logic              room,
  output logic [CNT_W-1:0]  used,
  output logic [CNT_W-1:0]  peak
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] after_rel;
  logic [CNT_W-1:0] used_nxt;

  assign rel_ok    = rel_req && (used != '0);
  assign after_rel = used - CNT_W'(rel_ok);
  assign alloc_ok  = alloc_req && rmt_can_take(POOL_LIMIT, int'(after_rel));
  assign used_nxt  = CNT_W'(rmt_sat_inc(int'(after_rel), alloc_ok, CNT_MAX));
  assign room      = rmt_has_room(POOL_LIMIT, int'(used), int'(need));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      peak <= '0;
    end else begin
      used <= used_nxt;
      peak <= CNT_W'(rmt_max(int'(peak), int'(used_nxt)));
    end
  end

endmodule

// File: rtl/rmt_life_ctr.sv
module rmt_life_ctr
  import rmt_pkg::*;
#(
  parameter int LIFE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bump,
  output logic [LIFE_W-1:0] count
);

  localparam int LIFE_MAX = (LIFE_W >= 31) ? 32'h7fff_ffff : ((1 << LIFE_W) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= LIFE_W'(rmt_sat_inc(int'(count), bump, LIFE_MAX));
  end

endmodule

// File: rtl/rename_map_tracker.sv
module rename_map_tracker #(
  parameter int NUM_REGS   = 16,
  parameter int TAG_W      = 5,
  parameter int POOL_LIMIT = 8,
  parameter int CNT_W      = 8,
  parameter int LIFE_W     = 16,
  parameter int NEED_W     = 4,
  localparam int REG_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              rel_valid,
  input  logic [TAG_W-1:0]  rel_tag,
  input  logic [REG_W-1:0]  query_reg,
  output logic              query_valid,
  output logic [TAG_W-1:0]  query_tag,
  input  logic [NEED_W-1:0] need_count,
  output logic              avail,
  output logic [CNT_W-1:0]  in_use,
  output logic [CNT_W-1:0]  peak_use,
  output logic [LIFE_W-1:0] total_created
);

  // Internal events, named for the checker.
  logic alloc_accept;
  logic rel_effective;

  rmt_pool_ctr #(
    .POOL_LIMIT (POOL_LIMIT),
    .CNT_W      (CNT_W),
    .NEED_W     (NEED_W)
  ) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (alloc_valid),
    .rel_req   (rel_valid),
    .need      (need_count),
    .alloc_ok  (alloc_accept),
    .rel_ok    (rel_effective),
    .room      (avail),
    .used      (in_use),
    .peak      (peak_use)
  );

  rmt_map_table #(
    .NUM_REGS (NUM_REGS),
    .TAG_W    (TAG_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (alloc_accept),
    .wr_reg   (alloc_reg),
    .wr_tag   (alloc_tag),
    .clr_en   (rel_valid),
    .clr_tag  (rel_tag),
    .rd_reg   (query_reg),
    .rd_valid (query_valid),
    .rd_tag   (query_tag)
  );

  rmt_life_ctr #(
    .LIFE_W (LIFE_W)
  ) u_life (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (alloc_accept),
    .count (total_created)
  );

endmodule

// File: rtl/rmt_checker.sv
module rmt_checker #(
  parameter int POOL_LIMIT = 8,
  parameter int CNT_W      = 8,
  parameter int LIFE_W     = 16,
  parameter int NEED_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              rel_valid,
  input logic              alloc_accept,
  input logic              rel_effective,
  input logic [NEED_W-1:0] need_count,
  input logic              avail,
  input logic [CNT_W-1:0]  in_use,
  input logic [CNT_W-1:0]  peak_use,
  input logic [LIFE_W-1:0] total_created
);

  localparam logic [LIFE_W-1:0] LMAX = '1;

  AST_INUSE_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (POOL_LIMIT != 0) |-> (int'(in_use) <= POOL_LIMIT)); // R5

  AST_REJECT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_accept |=> $stable(total_created)); // R5

  AST_IDLE_INUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_valid && !rel_valid) |=> $stable(in_use)); // R6

  AST_FULL_TAKES_WITH_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (POOL_LIMIT != 0 && int'(in_use) == POOL_LIMIT && alloc_valid && rel_valid)
      |-> alloc_accept); // R7

  AST_FULL_NOT_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (POOL_LIMIT != 0 && int'(in_use) == POOL_LIMIT && need_count != '0) |-> !avail); // R8

  AST_PEAK_COVERS_INUSE: assert property (@(posedge clk) disable iff (!rst_n)
    peak_use >= in_use); // R9

  AST_PEAK_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (peak_use >= $past(peak_use))); // R9

  AST_TOTAL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (total_created == LMAX) |=> (total_created == LMAX)); // R10

  AST_UNLIMITED_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (POOL_LIMIT == 0 && alloc_valid) |-> (alloc_accept && avail)); // R11

  AST_REL_AT_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_use == '0) |-> !rel_effective); // R6

endmodule

bind rename_map_tracker rmt_checker #(
  .POOL_LIMIT (POOL_LIMIT),
  .CNT_W      (CNT_W),
  .LIFE_W     (LIFE_W),
  .NEED_W     (NEED_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_valid   (alloc_valid),
  .rel_valid     (rel_valid),
  .alloc_accept  (alloc_accept),
  .rel_effective (rel_effective),
  .need_count    (need_count),
  .avail         (avail),
  .in_use        (in_use),
  .peak_use      (peak_use),
  .total_created (total_created)
);

// File: tb/sim_rename_map_tracker.sv
module sim_rename_map_tracker;

  localparam int CLK_PERIOD = 40;
  localparam int NR  = 4;
  localparam int TW  = 3;
  localparam int LIM = 3;
  localparam int CW  = 4;
  localparam int LW  = 4;
  localparam int NW  = 3;
  localparam int TOT_MAX = (1 << LW) - 1;
  localparam int U1_MAX  = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          a_v = 1'b0;
  logic [1:0]    a_r = '0;
  logic [TW-1:0] a_t = '0;
  logic          r_v = 1'b0;
  logic [TW-1:0] r_t = '0;
  logic [1:0]    q_r = '0;
  logic [NW-1:0] need = '0;

  logic          q_v0;
  logic [TW-1:0] q_t0;
  logic          av0;
  logic [CW-1:0] use0, peak0;
  logic [LW-1:0] tot0;

  logic          q_v1;
  logic [TW-1:0] q_t1;
  logic          av1;
  logic [7:0]    use1, peak1;
  logic [LW-1:0] tot1;

  rename_map_tracker #(.NUM_REGS(NR), .TAG_W(TW), .POOL_LIMIT(LIM), .CNT_W(CW),
                       .LIFE_W(LW), .NEED_W(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_valid(a_v), .alloc_reg(a_r), .alloc_tag(a_t),
    .rel_valid(r_v), .rel_tag(r_t), .query_reg(q_r), .query_valid(q_v0), .query_tag(q_t0),
    .need_count(need), .avail(av0), .in_use(use0), .peak_use(peak0), .total_created(tot0));

  rename_map_tracker #(.NUM_REGS(NR), .TAG_W(TW), .POOL_LIMIT(0), .CNT_W(8),
                       .LIFE_W(LW), .NEED_W(NW)) u1 (
    .clk(clk), .rst_n(rst_n), .alloc_valid(a_v), .alloc_reg(a_r), .alloc_tag(a_t),
    .rel_valid(r_v), .rel_tag(r_t), .query_reg(q_r), .query_valid(q_v1), .query_tag(q_t1),
    .need_count(need), .avail(av1), .in_use(use1), .peak_use(peak1), .total_created(tot1));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Model state.
  int m_v [NR];
  int m_t [NR];
  int m_use, m_peak, m_tot, m_use1;

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NR; i++) begin m_v[i] = 0; m_t[i] = 0; end
    m_use = 0; m_peak = 0; m_tot = 0; m_use1 = 0;
  endtask

  // Release first, then allocation against the post-release count.
  task automatic model_step();
    int rel_e, after, acc, rel1;
    rel_e = (r_v && m_use > 0) ? 1 : 0;
    after = m_use - rel_e;
    acc   = (a_v && after < LIM) ? 1 : 0;
    for (int i = 0; i < NR; i++) begin
      if (acc != 0 && int'(a_r) == i) begin m_v[i] = 1; m_t[i] = int'(a_t); end
      else if (r_v && m_v[i] != 0 && m_t[i] == int'(r_t)) m_v[i] = 0;
    end
    m_use = after + acc;
    if (m_use > m_peak) m_peak = m_use;
    if (acc != 0 && m_tot < TOT_MAX) m_tot++;
    rel1   = (r_v && m_use1 > 0) ? 1 : 0;
    m_use1 = m_use1 - rel1;
    if (a_v && m_use1 < U1_MAX) m_use1++;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Called at a falling edge; sweeps the combinational look-ups.
  task automatic check_all(input string lbl);
    for (int q = 0; q < NR; q++) begin
      q_r = 2'(q);
      #1;
      chk(int'(q_v0), m_v[q], $sformatf("%s R2/R3 reg%0d valid", lbl, q));
      if (m_v[q] != 0) chk(int'(q_t0), m_t[q], $sformatf("%s R2 reg%0d tag", lbl, q));
    end
    for (int n = 0; n < (1 << NW); n++) begin
      need = NW'(n);
      #1;
      chk(int'(av0), (n <= LIM - m_use) ? 1 : 0, $sformatf("%s R8 need=%0d", lbl, n));
    end
    chk(int'(av1), 1, {lbl, " R11 unlimited avail"});
    chk(int'(use0), m_use, {lbl, " R6 in_use"});
    chk(int'(peak0), m_peak, {lbl, " R9 peak"});
    chk(int'(tot0), m_tot, {lbl, " R10 total"});
    chk(int'(use1), m_use1, {lbl, " R11 unlimited in_use"});
  endtask

  task automatic op(input bit av, input int ar, input int at, input bit rv, input int rt,
                    input string lbl);
    a_v = av; a_r = 2'(ar); a_t = TW'(at); r_v = rv; r_t = TW'(rt);
    model_step();
    cyc();
    a_v = 1'b0; r_v = 1'b0;
    check_all(lbl);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    a_v = 1'b0; r_v = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    model_reset();
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check_all("R1 reset");

    // Fill the pool (R2), then overflow attempt (R5).
    op(1, 0, 1, 0, 0, "R2 fill0");
    op(1, 1, 2, 0, 0, "R2 fill1");
    op(1, 2, 3, 0, 0, "R2 fill2");
    op(1, 3, 4, 0, 0, "R5 reject");
    q_r = 2'd3; #1;
    chk(int'(q_v0), 0, "R5 rejected alloc leaves reg3 empty");
    chk(int'(tot0), 3, "R5 rejected alloc not counted");

    // Full pool, allocate and release together (R7).
    op(1, 3, 5, 1, 1, "R7 full swap");
    chk(int'(use0), 3, "R7 in_use stays at limit");
    q_r = 2'd0; #1;
    chk(int'(q_v0), 0, "R7 released reg0 cleared");

    // Same register allocated while its tag is released (R4).
    op(1, 1, 6, 1, 2, "R4 collide");
    q_r = 2'd1; #1;
    chk(int'(q_v0), 1, "R4 reg1 valid");
    chk(int'(q_t0), 6, "R4 reg1 new tag");

    // Overwrite a register (R2) then release the stale tag (R3).
    op(0, 0, 0, 1, 3, "R3 drop tag3");
    op(1, 3, 7, 0, 0, "R2 overwrite reg3");
    op(0, 0, 0, 1, 5, "R3 stale tag5");
    q_r = 2'd3; #1;
    chk(int'(q_v0), 1, "R3 stale release keeps reg3");
    chk(int'(q_t0), 7, "R3 stale release keeps tag7");

    // Drain, then release at zero (R6).
    op(0, 0, 0, 1, 6, "R6 drain");
    op(0, 0, 0, 1, 7, "R6 drain");
    op(0, 0, 0, 1, 7, "R6 drain");
    op(0, 0, 0, 1, 1, "R6 at zero");
    chk(int'(use0), 0, "R6 in_use stays zero");

    // Pseudo-random sweep; lifetime saturation occurs early (R10).
    do_reset();
    check_all("R1 reset2");
    for (int k = 0; k < 1500; k++) begin
      int rr, rt;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rr = int'(lfsr[9:8]);
      rt = lfsr[11] ? m_t[rr] : int'(lfsr[14:12]);
      op(lfsr[0] | lfsr[1], int'(lfsr[3:2]), int'(lfsr[6:4]),
         lfsr[7] | (lfsr[15] & lfsr[2]), rt, "sweep");
    end
    chk(int'(tot0), TOT_MAX, "R10 total saturated");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule